// File: doc/BRIEF.md
# March Memory Self-Test Controller

This block is a self-test engine for one single-port synchronous RAM. When started, it walks every address with a fixed march of six elements. The first element writes all-zero words. The next four elements each apply a read, a complement and a second read at every cell. The last element makes a final read pass. The total is fourteen RAM operations per cell.

A complement is issued as a write of the inverse of the value the controller expects in the cell. Every read result returns one cycle after it is issued and is compared against the expected word. The first mismatch is latched together with its address, the expected word and the word read back. The controller then either finishes the full march or stops early, as selected by an input. A one-cycle completion pulse closes every run.

The ordering of the march lets it expose several fault types:
- cells stuck at 0 or 1;
- cells that cannot make a rising or a falling transition;
- one-directional coupling between two cells;
- address decoder faults in which a write lands on extra cells.

Top module: `march_bist`

## Requirements
- R1: While reset is asserted and after its release, done_o, fail_o, mem_en_o and mem_we_o are all low.
- R2: A start sampled while idle runs exactly 14 x 2^ADDR_W RAM accesses, each marked by mem_en_o. done_o is high for exactly one cycle, 14 x 2^ADDR_W + 2 cycles after the edge that sampled start.
- R3: The access stream has six elements, in this order:
  - all addresses ascending, writing 0;
  - two ascending elements of read, complement, read at each address;
  - two descending elements of read, complement, read at each address;
  - one ascending read.
  Written words are all-zeros or all-ones, and mem_we_o is only high together with mem_en_o.
- R4: A complement writes the inverse of the expected cell value, so a fault-free RAM completes the run with fail_o low.
- R5: A read whose data differs from the expected word sets fail_o. On that failure, fail_addr_o, fail_exp_o and fail_rdata_o hold the failing address, the expected word and the word read back.
- R6: Only the first mismatch of a run is captured: later mismatches leave fail_o and the captured fields unchanged.
- R7: With stop_on_fail_i high, no access is issued after the cycle in which the mismatch is compared, and done_o follows two cycles after that cycle.
- R8: A start while a run is in progress is ignored: the access count and the done_o timing of the run are unchanged.
- R9: A start accepted while idle clears fail_o from the previous run.
- R10: A one-directional coupling fault, where a rising write on one cell inverts another cell, is detected whether the victim address is below or above the aggressor. A write that also lands on a second address is detected as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; sampled only while idle |
| stop_on_fail_i | input | 1 | Stop at the first mismatch instead of finishing the march |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| fail_o | output | 1 | A mismatch was seen in the current or most recent run |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_exp_o | output | DATA_W | Expected word at the first mismatch |
| fail_rdata_o | output | DATA_W | Word read back at the first mismatch |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable (read when low with mem_en_o high) |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, valid the cycle after a read access |

## Verification
The assertions assume that the RAM returns read data exactly one cycle after a read access. They also assume that stop_on_fail_i does not change while a run is in progress, since the early-stop and operation-budget properties depend on that mode staying the same. The bench's RAM model keeps that one-cycle read latency, including while a fault is injected. Fault settings and stop_on_fail_i change only between runs, while the controller is idle. The only start issued during a run is the one that checks that such a start is ignored.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int unsigned ELEM_W       = 3;
  localparam int unsigned OP_W         = 2;
  localparam int unsigned OPS_PER_CELL = 14;
  localparam logic [ELEM_W-1:0] LAST_ELEM = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} state_e;

  function automatic logic elem_down(input logic [ELEM_W-1:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

  function automatic logic [OP_W-1:0] elem_last_op(input logic [ELEM_W-1:0] e);
    return (e == 3'd0 || e == LAST_ELEM) ? 2'd0 : 2'd2;
  endfunction

  function automatic logic op_write(input logic [ELEM_W-1:0] e, input logic [OP_W-1:0] op);
    return (e == 3'd0) || (op == 2'd1);
  endfunction

  // value read or written by this op; every cell holds the same polarity at element start
  function automatic logic op_pol(input logic [ELEM_W-1:0] e, input logic [OP_W-1:0] op);
    logic base;
    if (e == 3'd0) return 1'b0;
    base = (e == 3'd2) || (e == 3'd4);
    return (op == 2'd0) ? base : ~base;
  endfunction
endpackage

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              halt_i,
  output logic              clr_o,
  output logic              acc_en_o,
  output logic              acc_we_o,
  output logic              acc_pol_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  state_e            state_q;
  logic [ELEM_W-1:0] elem_q, elem_nx;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q, addr_step, addr_first;
  logic              down, op_end, addr_end, seq_end;

  always_comb begin
    down       = elem_down(elem_q);
    elem_nx    = elem_q + 3'd1;
    op_end     = (op_q == elem_last_op(elem_q));
    addr_end   = down ? (addr_q == '0) : (addr_q == ADDR_MAX);
    seq_end    = op_end && addr_end && (elem_q == LAST_ELEM);
    addr_step  = down ? (addr_q - ADDR_ONE) : (addr_q + ADDR_ONE);
    addr_first = elem_down(elem_nx) ? ADDR_MAX : '0;
  end

  assign clr_o      = (state_q == ST_IDLE) && start_i;
  assign acc_en_o   = (state_q == ST_RUN);
  assign acc_we_o   = (state_q == ST_RUN) && op_write(elem_q, op_q);
  assign acc_pol_o  = op_pol(elem_q, op_q);
  assign acc_addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          elem_q  <= '0;
          op_q    <= '0;
          addr_q  <= '0;
        end
        ST_RUN: begin
          if (seq_end || halt_i) begin
            state_q <= ST_DRAIN;
          end else if (!op_end) begin
            op_q <= op_q + 2'd1;
          end else if (!addr_end) begin
            op_q   <= '0;
            addr_q <= addr_step;
          end else begin
            op_q   <= '0;
            elem_q <= elem_nx;
            addr_q <= addr_first;
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic              pol_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mismatch_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_rdata_o
);
  logic              rd_vld_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] rd_exp_q;

  assign mismatch_o = rd_vld_q && (rdata_i != rd_exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q  <= 1'b0;
      rd_addr_q <= '0;
      rd_exp_q  <= '0;
    end else begin
      rd_vld_q  <= rd_i;
      rd_addr_q <= addr_i;
      rd_exp_q  <= {DATA_W{pol_i}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o       <= 1'b0;
      fail_addr_o  <= '0;
      fail_exp_o   <= '0;
      fail_rdata_o <= '0;
    end else if (clr_i) begin
      fail_o       <= 1'b0;
      fail_addr_o  <= '0;
      fail_exp_o   <= '0;
      fail_rdata_o <= '0;
    end else if (mismatch_o && !fail_o) begin
      fail_o       <= 1'b1;
      fail_addr_o  <= rd_addr_q;
      fail_exp_o   <= rd_exp_q;
      fail_rdata_o <= rdata_i;
    end
  end
endmodule

// File: rtl/march_bist.sv
module march_bist #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_on_fail_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_rdata_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic clr, pol, mismatch;

  march_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .halt_i     (mismatch && stop_on_fail_i),
    .clr_o      (clr),
    .acc_en_o   (mem_en_o),
    .acc_we_o   (mem_we_o),
    .acc_pol_o  (pol),
    .acc_addr_o (mem_addr_o),
    .done_o     (done_o)
  );

  assign mem_wdata_o = {DATA_W{pol}};

  march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .rd_i         (mem_en_o && !mem_we_o),
    .pol_i        (pol),
    .addr_i       (mem_addr_o),
    .rdata_i      (mem_rdata_i),
    .mismatch_o   (mismatch),
    .fail_o       (fail_o),
    .fail_addr_o  (fail_addr_o),
    .fail_exp_o   (fail_exp_o),
    .fail_rdata_o (fail_rdata_o)
  );
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_on_fail_i,
  input logic              done_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] fail_addr_o,
  input logic [DATA_W-1:0] fail_exp_o,
  input logic [DATA_W-1:0] fail_rdata_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i
);
  localparam logic [31:0] BUDGET = 32'(14 * (2 ** ADDR_W));
  logic [31:0] acc_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_cnt_q <= '0;
    else if (done_o) acc_cnt_q <= '0;
    else             acc_cnt_q <= acc_cnt_q + {31'd0, mem_en_o};
  end

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_budget_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fail_o) |-> (acc_cnt_q == BUDGET));
  p_solid_wdata_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_en_o && (mem_wdata_o == '0 || mem_wdata_o == '1)));
  p_real_mismatch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> (fail_exp_o != fail_rdata_o));
  p_first_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> (fail_o && $stable(fail_addr_o) && $stable(fail_exp_o)
                              && $stable(fail_rdata_o)));
  p_quiet_at_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_en_o);
endmodule

bind march_bist march_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_on_fail_i(stop_on_fail_i),
  .done_o(done_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o), .fail_exp_o(fail_exp_o),
  .fail_rdata_o(fail_rdata_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
);

// File: tb/sim_march_bist.sv
module sim_march_bist;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NC = 1 << AW;
  localparam int BUDGET = 14 * NC;

  localparam logic [2:0] F_NONE = 3'd0, F_SA0 = 3'd1, F_SA1 = 3'd2, F_TF = 3'd3,
                         F_CF = 3'd4, F_ALIAS = 3'd5;

  typedef struct packed {
    logic [2:0] kind;
    logic [3:0] a0;
    logic [3:0] a1;
    logic [2:0] bitn;
    logic       stop;
    logic       xfail;
    logic [3:0] xaddr;
    logic [7:0] xexp;
    logic [7:0] xgot;
    logic [8:0] xacc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{F_NONE,  4'd0,  4'd0,  3'd0, 1'b0, 1'b0, 4'd0,  8'h00, 8'h00, 9'd224},
    '{F_SA0,   4'd5,  4'd0,  3'd0, 1'b0, 1'b1, 4'd5,  8'hFF, 8'hFE, 9'd224},
    '{F_SA1,   4'd9,  4'd0,  3'd3, 1'b0, 1'b1, 4'd9,  8'h00, 8'h08, 9'd224},
    '{F_TF,    4'd2,  4'd0,  3'd7, 1'b0, 1'b1, 4'd2,  8'hFF, 8'h7F, 9'd224},
    '{F_CF,    4'd3,  4'd10, 3'd0, 1'b0, 1'b1, 4'd10, 8'h00, 8'h01, 9'd224},
    '{F_CF,    4'd12, 4'd4,  3'd0, 1'b0, 1'b1, 4'd4,  8'hFF, 8'hFE, 9'd224},
    '{F_ALIAS, 4'd6,  4'd13, 3'd0, 1'b0, 1'b1, 4'd13, 8'h00, 8'hFF, 9'd224},
    '{F_SA1,   4'd9,  4'd0,  3'd3, 1'b1, 1'b1, 4'd9,  8'h00, 8'h08, 9'd45},
    '{F_SA0,   4'd5,  4'd0,  3'd0, 1'b1, 1'b1, 4'd5,  8'hFF, 8'hFE, 9'd35}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic done, fail, en, we;
  logic [AW-1:0] faddr, addr;
  logic [DW-1:0] fexp, fgot, wdata, rdata;

  always #2 clk = ~clk;

  march_bist #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_on_fail_i(stop),
    .done_o(done), .fail_o(fail), .fail_addr_o(faddr), .fail_exp_o(fexp),
    .fail_rdata_o(fgot), .mem_en_o(en), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  // RAM model with one injectable fault
  logic [DW-1:0] mem [NC];
  logic [2:0] f_kind = F_NONE;
  logic [AW-1:0] f_a0 = '0, f_a1 = '0;
  logic [2:0] f_bit = '0;

  always @(posedge clk) begin
    logic [DW-1:0] old, nw;
    if (en) begin
      if (we) begin
        old = mem[addr];
        nw  = wdata;
        if (addr == f_a0) begin
          if (f_kind == F_SA0) nw[f_bit] = 1'b0;
          if (f_kind == F_SA1) nw[f_bit] = 1'b1;
          if (f_kind == F_TF && !old[f_bit] && nw[f_bit]) nw[f_bit] = 1'b0;
        end
        mem[addr] = nw;
        if (addr == f_a0 && f_kind == F_CF && !old[f_bit] && nw[f_bit])
          mem[f_a1][f_bit] = ~mem[f_a1][f_bit];
        if (addr == f_a0 && f_kind == F_ALIAS) mem[f_a1] = wdata;
      end else begin
        nw = mem[addr];
        if (addr == f_a0 && f_kind == F_SA0) nw[f_bit] = 1'b0;
        if (addr == f_a0 && f_kind == F_SA1) nw[f_bit] = 1'b1;
        rdata <= nw;
      end
    end
  end

  int checks = 0, errors = 0;
  logic log_we [BUDGET];
  logic [AW-1:0] log_addr [BUDGET];
  logic [DW-1:0] log_wd [BUDGET];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input vec_t v, input int restart_at, output int acc, output int done_at);
    int cyc;
    for (int i = 0; i < NC; i++) mem[i] = '0;
    f_kind = v.kind; f_a0 = v.a0; f_a1 = v.a1; f_bit = v.bitn;
    stop = v.stop;
    start = 1'b1;
    acc = 0; done_at = 0; cyc = 0;
    while (cyc < 1000 && done_at == 0) begin
      @(negedge clk);
      cyc++;
      start = (cyc == restart_at);
      if (cyc == 1) chk(fail == 1'b0, "R9", "fail cleared on start", 32'(fail), 32'd0);
      if (en) begin
        if (acc < BUDGET) begin
          log_we[acc] = we; log_addr[acc] = addr; log_wd[acc] = wdata;
        end
        acc++;
      end
      if (done) done_at = cyc;
    end
    start = 1'b0;
    chk(done_at != 0, "R2", "watchdog: done never seen", 32'(cyc), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R2", "done is a single-cycle pulse", 32'(done), 32'd0);
  endtask

  task automatic check_result(input vec_t v, input int acc, input int done_at, input string req);
    chk(acc == int'(v.xacc), v.stop ? "R7" : "R2", "access count", 32'(acc), 32'(v.xacc));
    chk(done_at == int'(v.xacc) + 2, v.stop ? "R7" : "R2", "done latency", 32'(done_at),
        32'(v.xacc + 2));
    chk(fail == v.xfail, req, "fail flag", 32'(fail), 32'(v.xfail));
    if (v.xfail) begin
      chk(faddr == v.xaddr, req, "fail address", 32'(faddr), 32'(v.xaddr));
      chk(fexp == v.xexp, req, "expected word", 32'(fexp), 32'(v.xexp));
      chk(fgot == v.xgot, req, "read word (first failure, R6)", 32'(fgot), 32'(v.xgot));
    end
  endtask

  initial begin
    int acc, done_at, k, bad;
    logic p;
    string req;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({done, fail, en, we} == 4'b0, "R1", "outputs in reset", 32'({done, fail, en, we}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({done, fail, en, we} == 4'b0, "R1", "outputs after reset", 32'({done, fail, en, we}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_case(VECS[i], 0, acc, done_at);
      case (VECS[i].kind)
        F_NONE:  req = "R4";
        F_CF, F_ALIAS: req = "R10";
        default: req = "R5";
      endcase
      check_result(VECS[i], acc, done_at, req);
      if (i == 0) begin
        // R3: compare the full access stream against an independent march model
        bad = 0; k = 0; p = 1'b0;
        for (int e = 0; e < 6; e++) begin
          for (int a = 0; a < NC; a++) begin
            int ca;
            ca = (e == 3 || e == 4) ? NC - 1 - a : a;
            for (int o = 0; o < ((e == 0 || e == 5) ? 1 : 3); o++) begin
              logic xw;
              logic [DW-1:0] xd;
              xw = (e == 0) || (o == 1);
              xd = (e == 0) ? '0 : {DW{~p}};
              if (log_we[k] != xw || log_addr[k] != AW'(ca) || (xw && log_wd[k] != xd)) bad++;
              k++;
            end
          end
          if (e != 0 && e != 5) p = ~p;
        end
        chk(bad == 0, "R3", "march access stream mismatches", 32'(bad), 32'd0);
      end
    end

    // R8: a start during the run is ignored
    run_case(VECS[0], 50, acc, done_at);
    chk(acc == BUDGET, "R8", "access count with mid-run start", 32'(acc), 32'(BUDGET));
    chk(done_at == BUDGET + 2, "R8", "done latency with mid-run start", 32'(done_at),
        32'(BUDGET + 2));
    repeat (3) @(negedge clk);
    chk(en == 1'b0, "R8", "no second run after done", 32'(en), 32'd0);

    // R9: a failing run followed by a clean one clears fail
    run_case(VECS[2], 0, acc, done_at);
    chk(fail == 1'b1, "R5", "fail before clean rerun", 32'(fail), 32'd1);
    run_case(VECS[0], 0, acc, done_at);
    chk(fail == 1'b0, "R9", "fail after clean rerun", 32'(fail), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule